// File: doc/BRIEF.md
# Grid Scan and Dimming Generator

This block produces the time-multiplexed drive pattern for a vacuum fluorescent display. The display has a display memory of 11 words of 16 bits. The block lights one grid for each digit slot and gates that digit's segment bits with a programmable duty. After the last digit it inserts one extra slot, in which the grids and segments stay dark so that a key matrix can be scanned on the shared segment lines. A free-running sub-tick, supplied from outside, paces the scan. Each slot lasts sixteen sub-ticks.

Two command strobes configure the block, and both are decoded elsewhere. The mode write picks how many grids are used. Five output pins serve either as segment 12..16 or as grid 11..7, so adding digits removes segments from the top of the segment field. The display-control write carries the on/off bit and a 3-bit brightness code. The block fetches display words through a word-index read port. It latches each word at the boundary before that word's slot, so a memory update never tears a digit that is already being shown.

Top module: `grid_scan_dimmer`

## Requirements
- R1: After reset the mode is code 7 (11 digits, 11 segments), the display is off, brightness code is 0, and key scanning is stopped. All of seg_en, grid_en, shared_pin, key_slot and frame_end are 0, and they stay 0 under sub-ticks until a display-control write.
- R2: Mode code m selects n = m+4 digits. The segment count is 16 for codes 0 to 2 and 22-n for codes 3 to 7. seg_en bits at or above the segment count are always 0.
- R3: shared_pin[i] (i = 0..4) drives segment bit 11+i OR grid bit 10-i. A segment bit and the grid bit on the same pin are never both high.
- R4: A running frame is n+1 slots of 16 sub-ticks. In slot k < n, grid_en is one-hot at bit k for all 16 sub-ticks. Slot n is the key slot: key_slot is 1, and grid_en and seg_en are 0.
- R5: Within a digit slot, segments are on while the sub-tick index (0..15) is below the threshold picked by the brightness code. Codes 0..7 give thresholds 1, 2, 4, 10, 11, 12, 13 and 14.
- R6: A display-control write takes bit 3 as on/off and bits 2:0 as brightness, and starts the scan. With the display off, seg_en, grid_en and shared_pin are 0, but key_slot and frame_end keep following the frame.
- R7: A mode write with a code that differs from the current one turns the display off, stops the scan and restarts it at slot 0, sub-tick 0. A mode write with the current code changes nothing.
- R8: mem_addr presents the word index of the next digit slot. seg_en shows the word captured at the final sub-tick of the previous slot, so a memory change during a slot appears only at a later visit to that slot.
- R9: frame_end is a one-cycle pulse in the clock cycle after the edge that takes the last sub-tick of the key slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | One pulse per sixteenth of a slot |
| mode_wr | input | 1 | Mode command strobe |
| mode_code | input | 3 | Digit/segment mode code |
| ctrl_wr | input | 1 | Display-control command strobe |
| ctrl_code | input | 4 | Bit 3 on/off, bits 2:0 brightness |
| mem_addr | output | 4 | Display memory word index to read |
| mem_data | input | 16 | Display memory word at mem_addr |
| seg_en | output | 16 | Segment enables, bit j is segment j+1 |
| grid_en | output | 11 | Grid enables, bit k is grid k+1 |
| shared_pin | output | 5 | Merged segment 12..16 / grid 11..7 pins |
| key_slot | output | 1 | High during the key-scan slot |
| frame_end | output | 1 | Pulse after the last key-slot sub-tick |

## Verification
The outputs are decoded from registers. The clock edge that samples a sub-tick or a command strobe changes seg_en, grid_en, shared_pin and key_slot within that same cycle. frame_end passes through one more register, so it is high for the single cycle after the edge that takes the final key-slot sub-tick. The bench drives every input on a falling edge and holds it for one cycle. It compares all outputs against a requirement-level model at the next falling edge, which is half a cycle after the edge that updates them. Memory words are changed only on falling edges, at least one full cycle before the edge that should or should not capture them.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

    localparam int SEG_W      = 16;
    localparam int GRID_W     = 11;
    localparam int SHARED_N   = 5;
    localparam int FULL_GRIDS = GRID_W - SHARED_N;
    localparam int MIN_DIGITS = 4;
    localparam int MODE_W     = 3;
    localparam int DIM_W      = 3;
    localparam int SUB_W      = 4;
    localparam int SLOT_W     = $clog2(GRID_W + 1);
    localparam int THR_W      = SUB_W + 1;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_AT_RESET = mode_t'((1 << MODE_W) - 1);

    typedef struct packed {
        logic              on;
        logic [DIM_W-1:0]  dim;
    } disp_ctrl_t;

    // Number of active grids for a mode code.
    function automatic logic [SLOT_W-1:0] digits_of(mode_t m);
        return SLOT_W'(m) + SLOT_W'(MIN_DIGITS);
    endfunction

    // Segments left once shared pins are taken as grids.
    function automatic int seg_count(mode_t m);
        int d;
        d = int'(digits_of(m));
        return (d > FULL_GRIDS) ? SEG_W - (d - FULL_GRIDS) : SEG_W;
    endfunction

    function automatic logic [SEG_W-1:0] seg_mask(mode_t m);
        logic [SEG_W-1:0] r;
        int c;
        c = seg_count(m);
        for (int i = 0; i < SEG_W; i++) r[i] = (i < c);
        return r;
    endfunction

    // Non-linear on-time table, in sub-ticks per slot.
    function automatic logic [THR_W-1:0] dim_threshold(logic [DIM_W-1:0] d);
        case (d)
            3'd0:    return THR_W'(1);
            3'd1:    return THR_W'(2);
            3'd2:    return THR_W'(4);
            3'd3:    return THR_W'(10);
            3'd4:    return THR_W'(11);
            3'd5:    return THR_W'(12);
            3'd6:    return THR_W'(13);
            default: return THR_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/gsd_cmd_regs.sv
module gsd_cmd_regs
    import gsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr,
    input  mode_t            mode_code,
    input  logic             ctrl_wr,
    input  logic [DIM_W:0]   ctrl_code,
    output mode_t            mode_q,
    output disp_ctrl_t       ctrl_q,
    output logic             run_q,
    output logic             restart
);

    assign restart = mode_wr && (mode_code != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_AT_RESET;
            ctrl_q <= '0;
            run_q  <= 1'b0;
        end else if (restart) begin
            mode_q    <= mode_code;
            ctrl_q.on <= 1'b0;
            run_q     <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_q <= disp_ctrl_t'(ctrl_code);
            run_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/gsd_slot_timer.sv
module gsd_slot_timer #(
    parameter int SLOT_BITS = 4,
    parameter int SUB_BITS  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 restart,
    input  logic                 sub_tick,
    input  logic [SLOT_BITS-1:0] digits,
    output logic [SLOT_BITS-1:0] slot,
    output logic [SUB_BITS-1:0]  sub,
    output logic [SLOT_BITS-1:0] next_slot,
    output logic                 slot_end,
    output logic                 frame_end
);

    localparam logic [SUB_BITS-1:0] SUB_LAST = '1;

    assign slot_end  = run && sub_tick && (sub == SUB_LAST);
    assign next_slot = (slot == digits) ? '0 : slot + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            slot <= '0;
            sub  <= '0;
        end else if (sub_tick) begin
            sub <= sub + 1'b1;
            if (sub == SUB_LAST) slot <= next_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) frame_end <= 1'b0;
        else     frame_end <= slot_end && (slot == digits) && !restart;
    end

endmodule

// File: rtl/gsd_seg_latch.sv
module gsd_seg_latch #(
    parameter int DATA_BITS = 16,
    parameter int SLOT_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 slot_end,
    input  logic [SLOT_BITS-1:0] next_slot,
    input  logic [SLOT_BITS-1:0] digits,
    input  logic [DATA_BITS-1:0] mem_data,
    output logic [SLOT_BITS-1:0] mem_addr,
    output logic [DATA_BITS-1:0] seg_lat
);

    logic next_is_key;

    assign next_is_key = (next_slot == digits);
    assign mem_addr    = (!run || next_is_key) ? '0 : next_slot;

    always_ff @(posedge clk) begin
        if (rst)           seg_lat <= '0;
        else if (!run)     seg_lat <= mem_data;
        else if (slot_end) seg_lat <= next_is_key ? '0 : mem_data;
    end

endmodule

// File: rtl/gsd_pattern.sv
module gsd_pattern
    import gsd_pkg::*;
(
    input  logic               run,
    input  disp_ctrl_t         ctrl,
    input  mode_t              mode,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [SUB_W-1:0]   sub,
    input  logic [SEG_W-1:0]   seg_lat,
    output logic [SEG_W-1:0]   seg_en,
    output logic [GRID_W-1:0]  grid_en,
    output logic [SHARED_N-1:0] shared_pin,
    output logic               key_slot
);

    logic [SLOT_W-1:0] digits;
    logic              active;
    logic              seg_on;

    assign digits   = digits_of(mode);
    assign key_slot = run && (slot == digits);
    assign active   = ctrl.on && run && !key_slot;
    assign seg_on   = active && ({1'b0, sub} < dim_threshold(ctrl.dim));
    assign grid_en  = active ? (GRID_W'(1) << slot) : '0;
    assign seg_en   = seg_on ? (seg_lat & seg_mask(mode)) : '0;

    for (genvar i = 0; i < SHARED_N; i++) begin : g_shared
        assign shared_pin[i] = seg_en[SEG_W-SHARED_N+i] | grid_en[GRID_W-1-i];
    end

endmodule

// File: rtl/grid_scan_dimmer.sv
module grid_scan_dimmer
    import gsd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sub_tick,
    input  logic                 mode_wr,
    input  logic [MODE_W-1:0]    mode_code,
    input  logic                 ctrl_wr,
    input  logic [DIM_W:0]       ctrl_code,
    output logic [SLOT_W-1:0]    mem_addr,
    input  logic [SEG_W-1:0]     mem_data,
    output logic [SEG_W-1:0]     seg_en,
    output logic [GRID_W-1:0]    grid_en,
    output logic [SHARED_N-1:0]  shared_pin,
    output logic                 key_slot,
    output logic                 frame_end
);

    mode_t             mode_q;
    disp_ctrl_t        ctrl_q;
    logic              run_q;
    logic              restart;
    logic              disp_on;
    logic [SLOT_W-1:0] digits;
    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  sub;
    logic [SLOT_W-1:0] next_slot;
    logic              slot_end;
    logic [SEG_W-1:0]  seg_lat;

    assign disp_on = ctrl_q.on;
    assign digits  = digits_of(mode_q);

    gsd_cmd_regs u_cmd (
        .clk       (clk),
        .rst       (rst),
        .mode_wr   (mode_wr),
        .mode_code (mode_code),
        .ctrl_wr   (ctrl_wr),
        .ctrl_code (ctrl_code),
        .mode_q    (mode_q),
        .ctrl_q    (ctrl_q),
        .run_q     (run_q),
        .restart   (restart)
    );

    gsd_slot_timer #(
        .SLOT_BITS (SLOT_W),
        .SUB_BITS  (SUB_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (run_q),
        .restart   (restart),
        .sub_tick  (sub_tick),
        .digits    (digits),
        .slot      (slot),
        .sub       (sub),
        .next_slot (next_slot),
        .slot_end  (slot_end),
        .frame_end (frame_end)
    );

    gsd_seg_latch #(
        .DATA_BITS (SEG_W),
        .SLOT_BITS (SLOT_W)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .run       (run_q),
        .slot_end  (slot_end),
        .next_slot (next_slot),
        .digits    (digits),
        .mem_data  (mem_data),
        .mem_addr  (mem_addr),
        .seg_lat   (seg_lat)
    );

    gsd_pattern u_pattern (
        .run        (run_q),
        .ctrl       (ctrl_q),
        .mode       (mode_q),
        .slot       (slot),
        .sub        (sub),
        .seg_lat    (seg_lat),
        .seg_en     (seg_en),
        .grid_en    (grid_en),
        .shared_pin (shared_pin),
        .key_slot   (key_slot)
    );

endmodule

// File: rtl/gsd_checker.sv
module gsd_checker
    import gsd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sub_tick,
    input  logic                 mode_wr,
    input  logic [MODE_W-1:0]    mode_code,
    input  logic                 ctrl_wr,
    input  logic [SEG_W-1:0]     seg_en,
    input  logic [GRID_W-1:0]    grid_en,
    input  logic [SHARED_N-1:0]  shared_pin,
    input  logic                 key_slot,
    input  logic                 frame_end,
    input  mode_t                mode_q,
    input  logic                 disp_on
);

    // R4
    grid_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grid_en));

    // R3
    shared_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_en[15:11] & {grid_en[6], grid_en[7], grid_en[8], grid_en[9], grid_en[10]}) == 5'd0);

    // R4
    key_blank_chk: assert property (@(posedge clk) disable iff (rst)
        key_slot |-> (grid_en == '0) && (seg_en == '0));

    // R6
    off_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !disp_on |-> (grid_en == '0) && (seg_en == '0) && (shared_pin == '0));

    // R7
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && (mode_code != mode_q) && !ctrl_wr) |=> (!disp_on && !key_slot));

    // R9
    fe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    // R2
    seg_top_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q >= 3'd3) |-> (seg_en[15] == 1'b0));

    // R4
    grid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sub_tick && !mode_wr && !ctrl_wr) |=> $stable(grid_en));

endmodule

bind grid_scan_dimmer gsd_checker u_chk (.*);

// File: tb/grid_scan_dimmer_bench.sv
module grid_scan_dimmer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        sub_tick;
    logic        mode_wr;
    logic [2:0]  mode_code;
    logic        ctrl_wr;
    logic [3:0]  ctrl_code;
    logic [3:0]  mem_addr;
    logic [15:0] mem_data;
    logic [15:0] seg_en;
    logic [10:0] grid_en;
    logic [4:0]  shared_pin;
    logic        key_slot;
    logic        frame_end;

    logic [15:0] mem [11];

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference model state
    int          m_mode, m_dim, m_slot, m_sub;
    bit          m_on, m_run, m_fe;
    logic [15:0] m_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_data = (mem_addr < 4'd11) ? mem[mem_addr] : 16'h0000;

    grid_scan_dimmer u_grid_scan_dimmer (
        .clk        (clk),
        .rst        (rst),
        .sub_tick   (sub_tick),
        .mode_wr    (mode_wr),
        .mode_code  (mode_code),
        .ctrl_wr    (ctrl_wr),
        .ctrl_code  (ctrl_code),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .seg_en     (seg_en),
        .grid_en    (grid_en),
        .shared_pin (shared_pin),
        .key_slot   (key_slot),
        .frame_end  (frame_end)
    );

    function automatic int b_segs(int m);
        case (m)
            0, 1, 2: return 16;
            3:       return 15;
            4:       return 14;
            5:       return 13;
            6:       return 12;
            default: return 11;
        endcase
    endfunction

    function automatic int b_thr(int d);
        case (d)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 10;
            4: return 11;
            5: return 12;
            6: return 13;
            default: return 14;
        endcase
    endfunction

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        int          n;
        logic [15:0] es;
        logic [10:0] eg;
        logic [4:0]  esh;
        logic        ek;
        n  = m_mode + 4;
        ek = m_run && (m_slot == n);
        es = '0;
        eg = '0;
        if (m_on && m_run && (m_slot < n)) begin
            eg[m_slot] = 1'b1;
            if (m_sub < b_thr(m_dim))
                for (int i = 0; i < b_segs(m_mode); i++) es[i] = m_lat[i];
        end
        for (int i = 0; i < 5; i++) esh[i] = es[11+i] | eg[10-i];
        cmp(tag, "seg_en",     32'(seg_en),     32'(es));
        cmp(tag, "grid_en",    32'(grid_en),    32'(eg));
        cmp(tag, "shared_pin", 32'(shared_pin), 32'(esh));
        cmp(tag, "key_slot",   32'(key_slot),   32'(ek));
        cmp(tag, "frame_end",  32'(frame_end),  32'(m_fe));
    endtask

    task automatic do_tick(string tag);
        int n;
        @(negedge clk) sub_tick = 1'b1;
        @(negedge clk) sub_tick = 1'b0;
        n = m_mode + 4;
        m_fe = 0;
        if (m_run) begin
            if (m_sub == 15) begin
                m_sub = 0;
                if (m_slot == n) begin
                    m_fe   = 1;
                    m_slot = 0;
                end else begin
                    m_slot++;
                end
                m_lat = (m_slot == n) ? 16'h0000 : mem[m_slot];
            end else begin
                m_sub++;
            end
        end
        check_outputs(tag);
    endtask

    task automatic run_ticks(int count, string tag);
        for (int t = 0; t < count; t++) do_tick(tag);
    endtask

    task automatic cmd_mode(int code, string tag);
        @(negedge clk) begin mode_wr = 1'b1; mode_code = 3'(code); end
        @(negedge clk) mode_wr = 1'b0;
        m_fe = 0;
        if (code != m_mode) begin
            m_mode = code;
            m_on   = 0;
            m_run  = 0;
            m_slot = 0;
            m_sub  = 0;
        end
        check_outputs(tag);
    endtask

    task automatic cmd_ctrl(bit on, int dim, string tag);
        @(negedge clk) begin ctrl_wr = 1'b1; ctrl_code = {on, 3'(dim)}; end
        @(negedge clk) ctrl_wr = 1'b0;
        m_fe = 0;
        if (!m_run) m_lat = mem[0];
        m_run = 1;
        m_on  = on;
        m_dim = dim;
        check_outputs(tag);
    endtask

    task automatic t_reset;
        check_outputs("R1 reset");
        run_ticks(40, "R1 stopped after reset");
    endtask

    task automatic t_default_frames;
        cmd_ctrl(1'b1, 7, "R6 on");
        run_ticks(2 * 12 * 16, "R4 R9 R3 default mode frames");
    endtask

    task automatic t_dimming;
        for (int d = 0; d < 8; d++) begin
            cmd_ctrl(1'b1, d, "R5 dim write");
            run_ticks(12 * 16, "R5 dim frame");
        end
    endtask

    task automatic t_display_off;
        cmd_ctrl(1'b0, 3, "R6 off write");
        run_ticks(2 * 12 * 16, "R6 off keeps key scan");
    endtask

    task automatic t_mode_sweep;
        for (int m = 0; m < 7; m++) begin
            cmd_mode(m, "R7 new mode blanks");
            run_ticks(20, "R7 scan stopped");
            cmd_ctrl(1'b1, m, "R2 on");
            run_ticks(2 * (m + 5) * 16, "R2 R3 R4 mode frames");
        end
        cmd_mode(7, "R7 back to mode 7");
        cmd_ctrl(1'b1, 7, "R2 on");
        run_ticks(12 * 16, "R2 R3 mode 7 frame");
    endtask

    task automatic t_same_mode;
        run_ticks(37, "R7 before same-mode write");
        cmd_mode(7, "R7 same mode ignored");
        run_ticks(12 * 16, "R7 scan continues");
    endtask

    task automatic t_latch;
        while (!(m_slot == 2 && m_sub == 3)) do_tick("R8 approach");
        @(negedge clk) mem[2] = 16'h07E1;
        run_ticks(12 * 16 + 20, "R8 latch holds then updates");
        cmp("R8", "mem_addr next word", 32'(mem_addr), (m_slot == 10) ? 32'd0 : 32'(m_slot + 1));
    endtask

    initial begin
        for (int k = 0; k < 11; k++) mem[k] = 16'hF800 | 16'(k * 37 + 1);
        mem[0]    = 16'hFFFF;
        rst       = 1'b1;
        sub_tick  = 1'b0;
        mode_wr   = 1'b0;
        mode_code = 3'd0;
        ctrl_wr   = 1'b0;
        ctrl_code = 4'd0;
        m_mode = 7; m_dim = 0; m_slot = 0; m_sub = 0;
        m_on = 0; m_run = 0; m_fe = 0; m_lat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset;
        t_default_frames;
        t_dimming;
        t_display_off;
        t_mode_sweep;
        t_same_mode;
        t_latch;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule